// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block derives the serial clock of a SPI shift engine from the fabric clock. It offers two divider formulas and a select input that picks one of them. The binary path divides the source by a power of two set by a 3-bit exponent: the full period is `2^(exp+2)` source cycles. The linear path divides by an even ratio set by an 8-bit divisor: the full period is `2*(div+1)` source cycles. Every ratio is even, so each serial-clock phase lasts exactly half a period.

Besides the level output, the block gives a one-cycle tick when each serial-clock period ends. The shift engine can use it as a bit-rate strobe. While the enable is low, the serial clock sits at a selectable idle level and the divider is held in its start state. A new ratio or path selection is taken up only when a period ends, so a period already in progress is never cut short or stretched.

Top module: `spi_clkdiv`

## Requirements
- R1: With `pathSel` = 0, one full `sclk` period lasts `2^(pow2Exp+2)` source cycles (exponent 0, 1, 2 and 3 give 4, 8, 16 and 32; exponent 7 gives 512).
- R2: With `pathSel` = 1, one full `sclk` period lasts `2*(enhDiv+1)` source cycles.
- R3: In every period, `sclk` spends exactly half the period away from the idle level and half at it, also when that half is an odd number of cycles.
- R4: One cycle after `enable` is sampled low, `sclk` equals `idlePol` and `bitTick` is 0, and both stay so while `enable` stays low. This also holds when `enable` drops in the middle of a period.
- R5: When `enable` is first sampled high at clock edge k, the first `sclk` transition away from idle follows edge k+H-1, where H is half the selected period.
- R6: `bitTick` is high for exactly one cycle per period, in the cycle in which `sclk` has just returned to the idle level, and at no other time.
- R7: A change of `pathSel`, `pow2Exp` or `enhDiv` while enabled leaves the current period at its old length; the new ratio applies from the next period.
- R8: The linear path covers its extremes: `enhDiv` = 0 toggles `sclk` every source cycle (ratio 2), and `enhDiv` = 255 gives ratio 512.
- R9: With `idlePol` = 1, `sclk` idles high and the first transition after enable goes low, with the same timing as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider; low holds `sclk` idle |
| idlePol | input | 1 | Idle level of `sclk` |
| pathSel | input | 1 | 0 selects the power-of-two path, 1 the linear path |
| pow2Exp | input | 3 | Exponent of the power-of-two path |
| enhDiv | input | 8 | Divisor field of the linear path |
| sclk | output | 1 | Divided serial clock, 50% duty |
| bitTick | output | 1 | One-cycle pulse at the end of each `sclk` period |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a period. The stimulus must hit a known cycle inside a running period, and the check must then see the old half-length finish before the new one starts. The bench starts the divider on a short ratio, switches to a longer linear ratio one cycle after enable, and checks `sclk` and `bitTick` at the exact samples where the old period ends and the first new-length period begins. A second directed case drops `enable` while `sclk` is away from idle, to show that the return to idle is immediate and free of glitches.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  // Strobes from the ratio control to the counting datapath.
  typedef struct packed {
    logic hold;       // divider disabled: park counter and clock
    logic toggle;     // half period elapsed: flip sclk and reload
    logic periodEnd;  // this toggle returns sclk to idle
  } divStrobe_t;

endpackage

// File: rtl/spi_clkdiv_ctrl.sv
module spi_clkdiv_ctrl
  import spi_clkdiv_pkg::*;
#(
  parameter int EXP_W   = 3,
  parameter int ENH_W   = 8,
  parameter int HAS_ENH = 1,
  parameter int CNT_W   = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             pathSel,
  input  logic [EXP_W-1:0] pow2Exp,
  input  logic [ENH_W-1:0] enhDiv,
  input  logic             cntZero,
  input  logic             phase,
  output divStrobe_t       strobe,
  output logic [CNT_W-1:0] loadVal
);

  logic [CNT_W-1:0] reqHalf;
  logic [CNT_W-1:0] activeHalf;
  logic             boundary;

  // Half-period length asked for by the current configuration.
  generate
    if (HAS_ENH != 0) begin : g_dualPath
      always_comb begin
        if (pathSel) reqHalf = CNT_W'(enhDiv) + CNT_W'(1);
        else         reqHalf = CNT_W'(2) << pow2Exp;
      end
    end else begin : g_pow2Only
      always_comb reqHalf = CNT_W'(2) << pow2Exp;
    end
  endgenerate

  always_comb begin
    strobe.hold      = !enable;
    strobe.toggle    = enable && cntZero;
    strobe.periodEnd = enable && cntZero && phase;
    boundary         = strobe.hold || strobe.periodEnd;
    loadVal          = (boundary ? reqHalf : activeHalf) - CNT_W'(1);
  end

  // The ratio in use is only replaced at a period boundary.
  always_ff @(posedge clk) begin
    if (!rstN)         activeHalf <= CNT_W'(2);
    else if (boundary) activeHalf <= reqHalf;
  end

  assert_phase_flips_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toggle |=> phase != $past(phase));

  assert_ratio_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(cntZero && phase)) |=> $stable(activeHalf));

  assert_half_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    activeHalf != '0);

endmodule

// File: rtl/spi_clkdiv_datapath.sv
module spi_clkdiv_datapath
  import spi_clkdiv_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idlePol,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic             cntZero,
  output logic             phase,
  output logic             sclk,
  output logic             bitTick
);

  logic [CNT_W-1:0] cnt;
  logic             phaseQ;
  logic             sclkQ;
  logic             tickQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= CNT_W'(1);
      phaseQ <= 1'b0;
      sclkQ  <= 1'b0;
      tickQ  <= 1'b0;
    end else if (strobe.hold) begin
      cnt    <= loadVal;
      phaseQ <= 1'b0;
      sclkQ  <= idlePol;
      tickQ  <= 1'b0;
    end else if (strobe.toggle) begin
      cnt    <= loadVal;
      phaseQ <= !phaseQ;
      sclkQ  <= !sclkQ;
      tickQ  <= strobe.periodEnd;
    end else begin
      cnt    <= cnt - CNT_W'(1);
      tickQ  <= 1'b0;
    end
  end

  assign cntZero = (cnt == '0);
  assign phase   = phaseQ;
  assign sclk    = sclkQ;
  assign bitTick = tickQ;

  assert_idle_park_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (sclkQ == $past(idlePol)) && !tickQ);

  assert_tick_at_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |-> !phaseQ);

  assert_sclk_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hold && !strobe.toggle) |=> $stable(sclkQ));

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_clkdiv_pkg::*;
#(
  parameter int EXP_W   = 3,
  parameter int ENH_W   = 8,
  parameter int HAS_ENH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             idlePol,
  input  logic             pathSel,
  input  logic [EXP_W-1:0] pow2Exp,
  input  logic [ENH_W-1:0] enhDiv,
  output logic             sclk,
  output logic             bitTick
);

  // Largest half period: 2^(2^EXP_W) on the binary path, 2^ENH_W on the linear one.
  localparam int POW2_BITS = (1 << EXP_W) + 1;
  localparam int ENH_BITS  = ENH_W + 1;
  localparam int CNT_W     = (POW2_BITS > ENH_BITS) ? POW2_BITS : ENH_BITS;

  divStrobe_t       strobe;
  logic [CNT_W-1:0] loadVal;
  logic             cntZero;
  logic             phase;

  spi_clkdiv_ctrl #(
    .EXP_W(EXP_W), .ENH_W(ENH_W), .HAS_ENH(HAS_ENH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pathSel(pathSel),
    .pow2Exp(pow2Exp), .enhDiv(enhDiv), .cntZero(cntZero), .phase(phase),
    .strobe(strobe), .loadVal(loadVal)
  );

  spi_clkdiv_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .idlePol(idlePol), .strobe(strobe),
    .loadVal(loadVal), .cntZero(cntZero), .phase(phase),
    .sclk(sclk), .bitTick(bitTick)
  );

  assert_tick_with_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (sclk == idlePol));

endmodule

// File: tb/tb_spi_clkdiv.sv
`timescale 1ns/1ps
module tb_spi_clkdiv;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       idlePol = 1'b0;
  logic       pathSel = 1'b0;
  logic [2:0] pow2Exp = 3'd0;
  logic [7:0] enhDiv = 8'd0;
  logic       sclk;
  logic       bitTick;

  int errors = 0;
  int checks = 0;

  spi_clkdiv dut (
    .clk(clk), .rstN(rstN), .enable(enable), .idlePol(idlePol),
    .pathSel(pathSel), .pow2Exp(pow2Exp), .enhDiv(enhDiv),
    .sclk(sclk), .bitTick(bitTick)
  );

  always #4 clk = ~clk;

  // Vector fields: {pathSel, idlePol, pow2Exp[2:0], enhDiv[7:0], half[9:0]}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'd0,   10'd2},
    {1'b0, 1'b0, 3'd1, 8'd0,   10'd4},
    {1'b0, 1'b0, 3'd3, 8'd0,   10'd16},
    {1'b0, 1'b0, 3'd7, 8'd0,   10'd256},
    {1'b1, 1'b0, 3'd0, 8'd0,   10'd1},
    {1'b1, 1'b0, 3'd0, 8'd2,   10'd3},
    {1'b1, 1'b0, 3'd0, 8'd9,   10'd10},
    {1'b1, 1'b0, 3'd0, 8'd255, 10'd256},
    {1'b0, 1'b1, 3'd2, 8'd0,   10'd8},
    {1'b1, 1'b1, 3'd0, 8'd4,   10'd5}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runVector(input logic sel, input logic pol, input logic [2:0] e,
                           input logic [7:0] d, input int half, input string tag);
    int badS = 0;
    int badT = 0;
    int firstEdge = -1;
    int away = 0;
    enable = 1'b0; pathSel = sel; idlePol = pol; pow2Exp = e; enhDiv = d;
    repeat (3) @(negedge clk);
    check(sclk == pol && !bitTick, "R4", "idle sclk before enable", sclk, pol);
    enable = 1'b1;
    for (int c = 1; c <= 5 * half; c++) begin
      logic expS;
      logic expT;
      int t;
      @(negedge clk);
      t = c - half;
      if (t < 0) expS = pol;
      else       expS = (((t / half) % 2) == 0) ? !pol : pol;
      expT = ((c % (2 * half)) == 0);
      if (sclk != expS) badS++;
      if (bitTick != expT) badT++;
      if (firstEdge < 0 && sclk != pol) firstEdge = c;
      if (c >= half && c < 3 * half && sclk != pol) away++;
    end
    check(badS == 0, tag, "sclk waveform mismatches", badS, 0);
    check(firstEdge == half, "R5", "first transition sample", firstEdge, half);
    check(away == half, "R3", "cycles away from idle in one period", away, half);
    check(badT == 0, "R6", "bitTick mismatches", badT, 0);
    enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0, "R4", "sclk after reset", sclk, 0);
    check(bitTick == 1'b0, "R4", "bitTick after reset", bitTick, 0);

    // Table walk: each vector checks the full waveform over 2.5 periods.
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      string tag;
      v = VEC[i];
      if (v[21])                                      tag = "R9";
      else if (v[22] && (v[17:10] == 8'd0 || v[17:10] == 8'd255)) tag = "R8";
      else if (v[22])                                 tag = "R2";
      else                                            tag = "R1";
      runVector(v[22], v[21], v[20:18], v[17:10], int'(v[9:0]), tag);
    end

    // R7: start with half 2, switch to linear half 5 inside the first period.
    enable = 1'b0; idlePol = 1'b0; pathSel = 1'b0; pow2Exp = 3'd0; enhDiv = 8'd4;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    begin
      logic s [1:16];
      logic k [1:16];
      for (int c = 1; c <= 16; c++) begin
        @(negedge clk);
        s[c] = sclk;
        k[c] = bitTick;
        if (c == 1) pathSel = 1'b1;
      end
      check(s[2] == 1'b1 && s[3] == 1'b1, "R7", "old half kept high", s[3], 1);
      check(s[4] == 1'b0 && k[4] == 1'b1, "R7", "old period ends at sample 4", s[4], 0);
      check(s[8] == 1'b0 && s[9] == 1'b1, "R7", "new half starts at sample 9", s[9], 1);
      check(s[13] == 1'b1 && s[14] == 1'b0 && k[14] == 1'b1, "R7",
            "new period ends at sample 14", s[14], 0);
    end

    // R4: disable while sclk is away from idle.
    enable = 1'b0; pathSel = 1'b0; pow2Exp = 3'd1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check(sclk == 1'b1, "R4", "sclk high before disable", sclk, 1);
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !bitTick, "R4", "sclk parked after disable", sclk, 0);
    begin
      int moved = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (sclk != 1'b0 || bitTick) moved++;
      end
      check(moved == 0, "R4", "activity while disabled", moved, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule